// File: doc/BRIEF.md
# Pipeline Hazard and Redirect Controller

This block steers a five-stage in-order integer pipeline (IF, ID, EX, MEM, WB). Each cycle it looks at the source registers of the instruction in decode and at the destination register, write flag and load flag of the instructions in execute and memory. It also takes the branch and jump outcome that execute produces. From these it drives the fetch and pipeline-register controls and the operand forwarding selects. It holds no datapath state. Its only storage is a valid bit per stage, which lets it tell a real instruction from a bubble, and the registered forwarding selects.

Control transfers resolve late, in EX. A taken branch or a jump therefore clears both younger stages in the cycle it is seen, and fetch restarts at the target. A load whose result is needed by the very next instruction costs one bubble. After that bubble the loaded value reaches the consumer through the memory-to-writeback forwarding path. Results produced by the ALU are forwarded without any stall. The register file is assumed to write before it reads, so a producer in WB needs no help from this block.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: While rst_ni is low and right after it rises, ifid_valid_o and idex_valid_o are 0, pc_sel_o is 0 (sequential PC+4), fwd_a_o and fwd_b_o are 0 (register file), pc_we_o is 1, and no clear, hold or bubble is asserted.
- R2: When EX holds a valid load (ex_reg_write_i=1, ex_is_load_i=1) whose nonzero ex_rd_i equals id_rs1_i or id_rs2_i, and ID holds a valid instruction, then pc_we_o=0, ifid_hold_o=1 and idex_bubble_o=1 in that same cycle. On the next cycle idex_valid_o=0 and ifid_valid_o stays 1.
- R3: Once the load has moved to MEM (mem_reg_write_i=1, mem_rd_i matching), the held consumer advances with no further stall. On the following cycle its matching operand select reads 2 (memory/writeback result).
- R4: A valid non-load producer in EX with reg write and a nonzero rd equal to an ID source makes that operand's select 1 (execute/memory ALU result) one cycle later, with no stall.
- R5: A valid producer in MEM with reg write and a nonzero rd equal to an ID source (ALU or load) makes that operand's select 2 one cycle later. Operands with no match read 0.
- R6: When both the EX and MEM producers match the same source, the select is 1, because the youngest producer wins.
- R7: Register 0 never causes a stall and never yields a nonzero forwarding select.
- R8: A taken branch in a valid EX stage (ex_branch_i=1, ex_branch_taken_i=1) sets ifid_clear_o=1, idex_clear_o=1 and pc_sel_o=1 in that cycle. On the next cycle ifid_valid_o=0 and idex_valid_o=0.
- R9: A jump in a valid EX stage (ex_jump_i=1) clears both registers and sets pc_sel_o=2 in that cycle.
- R10: A not-taken branch causes no clear and no stall, and pc_sel_o stays 0.
- R11: When a redirect and a load-use stall occur together, the redirect wins: pc_we_o=1, ifid_hold_o=0, idex_bubble_o=0, both clears are 1, and both selects read 0 on the next cycle.
- R12: While EX holds no valid instruction, branch, jump and load inputs are ignored: no clear, no stall, and pc_sel_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| id_rs1_i | input | 5 | First source register of the instruction in ID |
| id_rs2_i | input | 5 | Second source register of the instruction in ID |
| ex_rd_i | input | 5 | Destination register of the instruction in EX |
| ex_reg_write_i | input | 1 | Instruction in EX writes a register |
| ex_is_load_i | input | 1 | Instruction in EX is a load |
| mem_rd_i | input | 5 | Destination register of the instruction in MEM |
| mem_reg_write_i | input | 1 | Instruction in MEM writes a register |
| ex_branch_i | input | 1 | Instruction in EX is a conditional branch |
| ex_branch_taken_i | input | 1 | Branch condition evaluated true in EX |
| ex_jump_i | input | 1 | Instruction in EX is an unconditional jump |
| pc_we_o | output | 1 | PC write enable |
| ifid_hold_o | output | 1 | Hold the IF/ID register |
| idex_bubble_o | output | 1 | Load a zero-control bubble into ID/EX |
| ifid_clear_o | output | 1 | Clear IF/ID |
| idex_clear_o | output | 1 | Clear ID/EX |
| pc_sel_o | output | 2 | Next PC: 0 sequential, 1 branch target, 2 jump target |
| fwd_a_o | output | 2 | Operand A source in EX: 0 register file, 1 EX/MEM, 2 MEM/WB |
| fwd_b_o | output | 2 | Operand B source in EX: 0 register file, 1 EX/MEM, 2 MEM/WB |
| ifid_valid_o | output | 1 | IF/ID holds a real instruction |
| idex_valid_o | output | 1 | ID/EX holds a real instruction |

## Verification
The stall, hold, bubble, clear and PC-select outputs are combinational, so they are due in the same cycle as the EX and ID inputs that cause them. The forwarding selects and stage valid bits are registered and are due one clock edge later. The bench drives each stimulus on a falling edge and checks the combinational results 1 ns after it. It checks the registered results at the next falling edge, after exactly one rising edge. Load-use scenarios span two stimulus cycles, so that the bubble and the later forward select are each sampled in their own cycle.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    FWD_RF    = 2'd0,
    FWD_EXMEM = 2'd1,
    FWD_MEMWB = 2'd2
  } fwd_sel_e;

  typedef enum logic [1:0] {
    PC_SEQ    = 2'd0,
    PC_BRANCH = 2'd1,
    PC_JUMP   = 2'd2
  } pc_sel_e;
endpackage

// File: rtl/hz_occupancy.sv
// Tracks which stages hold real instructions.
module hz_occupancy (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stall_i,
  input  logic flush_i,
  output logic ifid_v_o,
  output logic idex_v_o,
  output logic exmem_v_o
);
  logic ifid_q, idex_q, exmem_q;
  logic ifid_d, idex_d;

  always_comb begin
    if (flush_i)      ifid_d = 1'b0;
    else if (stall_i) ifid_d = ifid_q;
    else              ifid_d = 1'b1;
    idex_d = ifid_q && !stall_i && !flush_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ifid_q  <= 1'b0;
      idex_q  <= 1'b0;
      exmem_q <= 1'b0;
    end else begin
      ifid_q  <= ifid_d;
      idex_q  <= idex_d;
      exmem_q <= idex_q;
    end
  end

  assign ifid_v_o  = ifid_q;
  assign idex_v_o  = idex_q;
  assign exmem_v_o = exmem_q;
endmodule

// File: rtl/hz_load_use.sv
module hz_load_use #(
  parameter int unsigned AW      = 5,
  parameter int unsigned NUM_SRC = 2
) (
  input  logic          ifid_v_i,
  input  logic          idex_v_i,
  input  logic [AW-1:0] rs_i [NUM_SRC],
  input  logic [AW-1:0] ex_rd_i,
  input  logic          ex_reg_write_i,
  input  logic          ex_is_load_i,
  output logic          stall_o
);
  logic [NUM_SRC-1:0] hit;
  logic               ld_live;

  assign ld_live = ifid_v_i && idex_v_i && ex_reg_write_i && ex_is_load_i
                   && (ex_rd_i != '0);

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    assign hit[s] = ld_live && (rs_i[s] == ex_rd_i);
  end

  assign stall_o = |hit;
endmodule

// File: rtl/hz_redirect.sv
module hz_redirect
  import hz_pkg::*;
(
  input  logic    idex_v_i,
  input  logic    ex_branch_i,
  input  logic    ex_branch_taken_i,
  input  logic    ex_jump_i,
  output logic    redirect_o,
  output pc_sel_e pc_sel_o
);
  logic take_br, take_jmp;

  assign take_jmp   = idex_v_i && ex_jump_i;
  assign take_br    = idex_v_i && ex_branch_i && ex_branch_taken_i;
  assign redirect_o = take_jmp || take_br;

  always_comb begin
    if (take_jmp)     pc_sel_o = PC_JUMP;
    else if (take_br) pc_sel_o = PC_BRANCH;
    else              pc_sel_o = PC_SEQ;
  end
endmodule

// File: rtl/hz_fwd_slot.sv
// Picks the operand source for the ID instruction; takes effect when it enters EX.
module hz_fwd_slot
  import hz_pkg::*;
#(
  parameter int unsigned AW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          advance_i,
  input  logic [AW-1:0] rs_i,
  input  logic          idex_v_i,
  input  logic [AW-1:0] ex_rd_i,
  input  logic          ex_reg_write_i,
  input  logic          ex_is_load_i,
  input  logic          exmem_v_i,
  input  logic [AW-1:0] mem_rd_i,
  input  logic          mem_reg_write_i,
  output fwd_sel_e      sel_o
);
  logic     ex_hit, mem_hit, rs_nz;
  fwd_sel_e sel_d, sel_q;

  assign rs_nz   = (rs_i != '0);
  assign ex_hit  = rs_nz && idex_v_i && ex_reg_write_i && !ex_is_load_i
                   && (ex_rd_i == rs_i);
  assign mem_hit = rs_nz && exmem_v_i && mem_reg_write_i && (mem_rd_i == rs_i);

  always_comb begin
    if (!advance_i)   sel_d = FWD_RF;
    else if (ex_hit)  sel_d = FWD_EXMEM;
    else if (mem_hit) sel_d = FWD_MEMWB;
    else              sel_d = FWD_RF;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= FWD_RF;
    else         sel_q <= sel_d;
  end

  assign sel_o = sel_q;
endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl
  import hz_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [4:0] id_rs1_i,
  input  logic [4:0] id_rs2_i,
  input  logic [4:0] ex_rd_i,
  input  logic       ex_reg_write_i,
  input  logic       ex_is_load_i,
  input  logic [4:0] mem_rd_i,
  input  logic       mem_reg_write_i,
  input  logic       ex_branch_i,
  input  logic       ex_branch_taken_i,
  input  logic       ex_jump_i,
  output logic       pc_we_o,
  output logic       ifid_hold_o,
  output logic       idex_bubble_o,
  output logic       ifid_clear_o,
  output logic       idex_clear_o,
  output logic [1:0] pc_sel_o,
  output logic [1:0] fwd_a_o,
  output logic [1:0] fwd_b_o,
  output logic       ifid_valid_o,
  output logic       idex_valid_o
);
  localparam int unsigned AW      = 5;
  localparam int unsigned NUM_SRC = 2;

  logic          ifid_v, idex_v, exmem_v;
  logic          stall_req, stall_eff, redirect, advance;
  pc_sel_e       pc_sel;
  logic [AW-1:0] rs_arr [NUM_SRC];
  fwd_sel_e      fwd_arr [NUM_SRC];

  assign rs_arr[0] = id_rs1_i;
  assign rs_arr[1] = id_rs2_i;

  hz_occupancy u_occ (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .stall_i   (stall_eff),
    .flush_i   (redirect),
    .ifid_v_o  (ifid_v),
    .idex_v_o  (idex_v),
    .exmem_v_o (exmem_v)
  );

  hz_load_use #(.AW(AW), .NUM_SRC(NUM_SRC)) u_lu (
    .ifid_v_i       (ifid_v),
    .idex_v_i       (idex_v),
    .rs_i           (rs_arr),
    .ex_rd_i        (ex_rd_i),
    .ex_reg_write_i (ex_reg_write_i),
    .ex_is_load_i   (ex_is_load_i),
    .stall_o        (stall_req)
  );

  hz_redirect u_rdr (
    .idex_v_i          (idex_v),
    .ex_branch_i       (ex_branch_i),
    .ex_branch_taken_i (ex_branch_taken_i),
    .ex_jump_i         (ex_jump_i),
    .redirect_o        (redirect),
    .pc_sel_o          (pc_sel)
  );

  // Redirect dominates a stall request.
  assign stall_eff = stall_req && !redirect;
  assign advance   = ifid_v && !stall_req && !redirect;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_fwd
    hz_fwd_slot #(.AW(AW)) u_slot (
      .clk_i           (clk_i),
      .rst_ni          (rst_ni),
      .advance_i       (advance),
      .rs_i            (rs_arr[s]),
      .idex_v_i        (idex_v),
      .ex_rd_i         (ex_rd_i),
      .ex_reg_write_i  (ex_reg_write_i),
      .ex_is_load_i    (ex_is_load_i),
      .exmem_v_i       (exmem_v),
      .mem_rd_i        (mem_rd_i),
      .mem_reg_write_i (mem_reg_write_i),
      .sel_o           (fwd_arr[s])
    );
  end

  assign pc_we_o       = !stall_eff;
  assign ifid_hold_o   = stall_eff;
  assign idex_bubble_o = stall_eff;
  assign ifid_clear_o  = redirect;
  assign idex_clear_o  = redirect;
  assign pc_sel_o      = pc_sel;
  assign fwd_a_o       = fwd_arr[0];
  assign fwd_b_o       = fwd_arr[1];
  assign ifid_valid_o  = ifid_v;
  assign idex_valid_o  = idex_v;
endmodule

// File: rtl/pipe_hazard_ctrl_chk.sv
module pipe_hazard_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [4:0] id_rs1_i,
  input logic [4:0] id_rs2_i,
  input logic       ex_branch_i,
  input logic       ex_branch_taken_i,
  input logic       ex_jump_i,
  input logic       pc_we_o,
  input logic       ifid_hold_o,
  input logic       idex_bubble_o,
  input logic       ifid_clear_o,
  input logic       idex_clear_o,
  input logic [1:0] pc_sel_o,
  input logic [1:0] fwd_a_o,
  input logic [1:0] fwd_b_o,
  input logic       ifid_valid_o,
  input logic       idex_valid_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_state_R1: assert (!ifid_valid_o && !idex_valid_o && fwd_a_o == 2'd0
                                     && fwd_b_o == 2'd0 && pc_sel_o == 2'd0 && pc_we_o);
    end
  end

  assert_stall_shape_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idex_bubble_o |-> (!pc_we_o && ifid_hold_o));

  assert_bubble_lands_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idex_bubble_o |=> (!idex_valid_o && ifid_valid_o));

  assert_flush_empties_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ifid_clear_o && idex_clear_o) |=> (!ifid_valid_o && !idex_valid_o));

  assert_flush_wins_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ifid_clear_o |-> (pc_we_o && !ifid_hold_o && !idex_bubble_o && pc_sel_o != 2'd0));

  assert_idle_ex_quiet_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idex_valid_o |-> (!ifid_clear_o && !idex_bubble_o && pc_sel_o == 2'd0));

  assert_not_taken_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_branch_i && !ex_branch_taken_i && !ex_jump_i) |-> (!ifid_clear_o && pc_sel_o == 2'd0));

  assert_x0_fwd_a_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_a_o != 2'd0) |-> ($past(id_rs1_i) != 5'd0));

  assert_x0_fwd_b_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_b_o != 2'd0) |-> ($past(id_rs2_i) != 5'd0));
endmodule

bind pipe_hazard_ctrl pipe_hazard_ctrl_chk u_chk (
  .clk_i             (clk_i),
  .rst_ni            (rst_ni),
  .id_rs1_i          (id_rs1_i),
  .id_rs2_i          (id_rs2_i),
  .ex_branch_i       (ex_branch_i),
  .ex_branch_taken_i (ex_branch_taken_i),
  .ex_jump_i         (ex_jump_i),
  .pc_we_o           (pc_we_o),
  .ifid_hold_o       (ifid_hold_o),
  .idex_bubble_o     (idex_bubble_o),
  .ifid_clear_o      (ifid_clear_o),
  .idex_clear_o      (idex_clear_o),
  .pc_sel_o          (pc_sel_o),
  .fwd_a_o           (fwd_a_o),
  .fwd_b_o           (fwd_b_o),
  .ifid_valid_o      (ifid_valid_o),
  .idex_valid_o      (idex_valid_o)
);

// File: tb/pipe_hazard_ctrl_tb.sv
module pipe_hazard_ctrl_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [4:0] id_rs1_i = '0, id_rs2_i = '0, ex_rd_i = '0, mem_rd_i = '0;
  logic       ex_reg_write_i = 0, ex_is_load_i = 0, mem_reg_write_i = 0;
  logic       ex_branch_i = 0, ex_branch_taken_i = 0, ex_jump_i = 0;
  logic       pc_we_o, ifid_hold_o, idex_bubble_o, ifid_clear_o, idex_clear_o;
  logic [1:0] pc_sel_o, fwd_a_o, fwd_b_o;
  logic       ifid_valid_o, idex_valid_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  pipe_hazard_ctrl u_dut (.*);

  task automatic chk(input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    id_rs1_i = '0; id_rs2_i = '0; ex_rd_i = '0; mem_rd_i = '0;
    ex_reg_write_i = 0; ex_is_load_i = 0; mem_reg_write_i = 0;
    ex_branch_i = 0; ex_branch_taken_i = 0; ex_jump_i = 0;
  endtask

  // Idle cycles; the pipeline fills with real instructions.
  task automatic settle(input int n);
    idle_inputs();
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic t_reset();
    #1;
    chk(ifid_valid_o, 0, "R1 ifid_valid in reset");
    chk(idex_valid_o, 0, "R1 idex_valid in reset");
    chk(pc_sel_o, 0, "R1 pc_sel in reset");
    chk(fwd_a_o, 0, "R1 fwd_a in reset");
    chk(fwd_b_o, 0, "R1 fwd_b in reset");
    chk(pc_we_o, 1, "R1 pc_we in reset");
    chk(ifid_clear_o | ifid_hold_o | idex_bubble_o, 0, "R1 no control in reset");
    @(negedge clk_i); rst_ni = 1;
  endtask

  task automatic t_idle_ex_ignored();
    // right after reset: IF/ID just filling, EX empty
    @(negedge clk_i);
    ex_branch_i = 1; ex_branch_taken_i = 1; ex_jump_i = 1;
    ex_is_load_i = 1; ex_reg_write_i = 1; ex_rd_i = 5'd4; id_rs1_i = 5'd4;
    #1;
    chk(ifid_clear_o, 0, "R12 no clear with EX empty");
    chk(pc_sel_o, 0, "R12 pc_sel with EX empty");
    chk(pc_we_o, 1, "R12 no stall with EX empty");
    settle(3);
    chk(idex_valid_o, 1, "R12 pipeline filled");
  endtask

  task automatic t_load_use();
    ex_is_load_i = 1; ex_reg_write_i = 1; ex_rd_i = 5'd5; id_rs1_i = 5'd5;
    #1;
    chk(pc_we_o, 0, "R2 pc_we during stall");
    chk(ifid_hold_o, 1, "R2 ifid_hold during stall");
    chk(idex_bubble_o, 1, "R2 bubble during stall");
    @(negedge clk_i);
    chk(idex_valid_o, 0, "R2 bubble in ID/EX");
    chk(ifid_valid_o, 1, "R2 IF/ID kept");
    chk(fwd_a_o, 0, "R2 no select for bubble");
    idle_inputs();
    mem_reg_write_i = 1; mem_rd_i = 5'd5; id_rs1_i = 5'd5;
    #1;
    chk(pc_we_o, 1, "R3 no second stall");
    @(negedge clk_i);
    chk(fwd_a_o, 2, "R3 load forwarded from MEM/WB");
    chk(fwd_b_o, 0, "R3 other operand from RF");
    settle(2);
  endtask

  task automatic t_ex_fwd();
    ex_reg_write_i = 1; ex_rd_i = 5'd8; id_rs2_i = 5'd8; id_rs1_i = 5'd3;
    #1;
    chk(pc_we_o, 1, "R4 no stall for ALU producer");
    @(negedge clk_i);
    chk(fwd_b_o, 1, "R4 EX/MEM forward");
    chk(fwd_a_o, 0, "R4 unmatched operand");
    settle(1);
  endtask

  task automatic t_mem_fwd();
    mem_reg_write_i = 1; mem_rd_i = 5'd9; id_rs2_i = 5'd9; id_rs1_i = 5'd1;
    @(negedge clk_i);
    chk(fwd_b_o, 2, "R5 MEM/WB forward");
    chk(fwd_a_o, 0, "R5 unmatched operand");
    settle(1);
  endtask

  task automatic t_priority();
    ex_reg_write_i = 1; ex_rd_i = 5'd7;
    mem_reg_write_i = 1; mem_rd_i = 5'd7;
    id_rs1_i = 5'd7; id_rs2_i = 5'd7;
    @(negedge clk_i);
    chk(fwd_a_o, 1, "R6 youngest wins on A");
    chk(fwd_b_o, 1, "R6 youngest wins on B");
    settle(1);
  endtask

  task automatic t_x0();
    ex_is_load_i = 1; ex_reg_write_i = 1; ex_rd_i = 5'd0;
    mem_reg_write_i = 1; mem_rd_i = 5'd0;
    id_rs1_i = 5'd0; id_rs2_i = 5'd0;
    #1;
    chk(pc_we_o, 1, "R7 x0 load causes no stall");
    @(negedge clk_i);
    chk(fwd_a_o, 0, "R7 x0 not forwarded A");
    chk(fwd_b_o, 0, "R7 x0 not forwarded B");
    settle(1);
  endtask

  task automatic t_branch_taken();
    ex_branch_i = 1; ex_branch_taken_i = 1;
    #1;
    chk(ifid_clear_o, 1, "R8 IF/ID clear");
    chk(idex_clear_o, 1, "R8 ID/EX clear");
    chk(pc_sel_o, 1, "R8 pc_sel branch");
    @(negedge clk_i);
    chk(ifid_valid_o, 0, "R8 IF/ID empty after flush");
    chk(idex_valid_o, 0, "R8 ID/EX empty after flush");
    #1;
    chk(ifid_clear_o, 0, "R12 branch ignored after flush");
    settle(3);
  endtask

  task automatic t_jump();
    ex_jump_i = 1;
    #1;
    chk(ifid_clear_o & idex_clear_o, 1, "R9 both clears on jump");
    chk(pc_sel_o, 2, "R9 pc_sel jump");
    settle(3);
  endtask

  task automatic t_not_taken();
    ex_branch_i = 1; ex_branch_taken_i = 0;
    #1;
    chk(ifid_clear_o | idex_clear_o, 0, "R10 no clear");
    chk(pc_sel_o, 0, "R10 sequential");
    chk(pc_we_o, 1, "R10 no stall");
    @(negedge clk_i);
    chk(ifid_valid_o & idex_valid_o, 1, "R10 pipeline intact");
    settle(1);
  endtask

  task automatic t_flush_vs_stall();
    ex_jump_i = 1; ex_is_load_i = 1; ex_reg_write_i = 1; ex_rd_i = 5'd6;
    id_rs1_i = 5'd6;
    #1;
    chk(pc_we_o, 1, "R11 PC written");
    chk(ifid_hold_o, 0, "R11 no hold");
    chk(idex_bubble_o, 0, "R11 no bubble");
    chk(ifid_clear_o & idex_clear_o, 1, "R11 clears");
    @(negedge clk_i);
    chk(fwd_a_o, 0, "R11 select A cleared");
    chk(fwd_b_o, 0, "R11 select B cleared");
    settle(3);
  endtask

  initial begin
    t_reset();
    t_idle_ex_ignored();
    t_load_use();
    t_ex_fwd();
    t_mem_fwd();
    t_priority();
    t_x0();
    t_branch_taken();
    t_jump();
    t_not_taken();
    t_flush_vs_stall();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 5000; i++) @(posedge clk_i);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule